// File: doc/BRIEF.md
# Transmit Timestamp Report Aggregator

This block gathers timestamp capture events from the egress datapath and turns them into a status stream in the AXI clock domain. Each event carries three values: a port number, the 8-bit tag that the frame submitter attached to the frame, and the full capture time. The egress side can present up to three events per cycle on parallel capture lanes. Lane 0 is the oldest and lane 2 is the newest. Accepted events wait in a small queue. Each cycle the block issues up to three of them on three report slots. Every slot has its own valid bit, its tag and the low 32 bits of the capture time. One shared port field applies to all slots of that cycle.

Only a leading run of events for the same port is issued together. When the port changes at the queue head, the next port waits for a later cycle. If the queue cannot take every lane that is offered, the extra lanes are dropped and a sticky overflow flag is raised. The flag is cleared by a dedicated input.

The overflow tracker is a two-state machine:
- OVF_CLEAN: no event has been lost.
- OVF_SEEN: at least one event has been lost since the last clear.

Its transitions are:
- OVF_CLEAN to OVF_SEEN on any drop.
- OVF_SEEN to OVF_CLEAN on a clear in a cycle with no drop.
- Otherwise the state holds.

Top module: `txts_report_agg`

## Requirements
- R1: While reset is low, and in the cycle after it is released, all report outputs read zero: valid is 000, port is 0, tags and timestamps are 0. The overflow flag is 0.
- R2: An event accepted at clock edge N into an empty queue is visible on the report outputs after edge N+1. Every accepted event is reported exactly once.
- R3: Reports leave in acceptance order, and lanes offered in the same cycle are accepted lowest lane first. Slots fill from slot 0 upward, so rpt_valid (bit k = slot k) is always one of 000, 001, 011 or 111.
- R4: Each cycle, as many queued events as possible are issued, up to three, subject to R5.
- R5: All reports in one cycle share the port field rpt_port. An event for a different port than the queue head waits for a later cycle.
- R6: Each valid slot's tag equals the tag supplied with that event.
- R7: Each valid slot's timestamp equals bits [31:0] of the capture time supplied with that event. The upper bits are discarded.
- R8: A slot whose valid bit is 0 drives zero tag and zero timestamp. rpt_port is 0 when no slot is valid.
- R9: Free space is taken as DEPTH minus the occupancy before the same-cycle issue. Offered lanes beyond that space are dropped, lowest lanes kept, and ovf_flag is 1 after that edge.
- R10: ovf_flag stays 1 until ovf_clr is sampled high in a cycle with no drop. A drop in the same cycle as ovf_clr keeps the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | AXI-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | LANES | Per-lane capture event valid; lane 0 is oldest |
| cap_port | input | 3*LANES | Port number per lane, lane k at bits [3k+2:3k] |
| cap_tag | input | 8*LANES | Frame tag per lane, lane k at bits [8k+7:8k] |
| cap_time | input | TIME_W*LANES | Full capture time per lane, lane k at bits [TIME_W*k +: TIME_W] |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| rpt_port | output | 3 | Port owning this cycle's reports |
| rpt_valid | output | 3 | Per-slot valid, bit k for slot k; also qualifies tags |
| rpt_tag_0 | output | 8 | Slot 0 tag |
| rpt_tag_1 | output | 8 | Slot 1 tag |
| rpt_tag_2 | output | 8 | Slot 2 tag |
| rpt_ts_0 | output | 32 | Slot 0 truncated timestamp |
| rpt_ts_1 | output | 32 | Slot 1 truncated timestamp |
| rpt_ts_2 | output | 32 | Slot 2 truncated timestamp |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
Two things can happen in the same cycle. The queue may drop surplus lanes while it is still issuing a port-split run, and the overflow flag may be set at the same edge that ovf_clr is asserted. The bench provokes both by offering three lanes with alternating ports in successive cycles until the queue fills. This forces single- and double-slot issues while lanes are being refused. It then asserts ovf_clr together with another over-full offer. A scoreboard holds only the lanes that the requirements say are kept, and compares every reported slot against it in order. The flag is judged 1 after the combined cycle and 0 only after a clear with no drop.

// File: rtl/txts_pkg.sv
package txts_pkg;
    localparam int PORT_W  = 3;
    localparam int TAG_W   = 8;
    localparam int RPT_W   = 32;
    localparam int NSLOT   = 3;
    localparam int PICK_W  = $clog2(NSLOT + 1);

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [TAG_W-1:0]  tag;
        logic [RPT_W-1:0]  ts;
    } cap_evt_t;
endpackage

// File: rtl/txts_fifo.sv
module txts_fifo
    import txts_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LANES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              in_valid,
    input  cap_evt_t [LANES-1:0]          in_evt,
    input  logic [PICK_W-1:0]             pop_n,
    output cap_evt_t [NSLOT-1:0]          head,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int RW = $clog2(LANES + 1);

    cap_evt_t          mem [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic [CW-1:0]     free;
    logic [RW-1:0]     rank [LANES];
    logic [LANES-1:0]  accept;
    logic [RW-1:0]     push_n;
    logic [RW-1:0]     acc;

    assign free = CW'(DEPTH) - count;

    always_comb begin
        acc    = '0;
        push_n = '0;
        drop   = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            rank[i]   = acc;
            accept[i] = in_valid[i] && (CW'(acc) < free);
            if (in_valid[i]) acc = acc + RW'(1);
            if (accept[i]) push_n = push_n + RW'(1);
            if (in_valid[i] && !accept[i]) drop = 1'b1;
        end
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_head
        assign head[k] = mem[PW'(rptr + PW'(k))];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (accept[i]) mem[PW'(wptr + PW'(rank[i]))] <= in_evt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= PW'(wptr + PW'(push_n));
            rptr  <= PW'(rptr + PW'(pop_n));
            count <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // R4: the packer never takes more entries than are queued
    p_pop_le_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= count);
    // R9: occupancy never exceeds the queue depth
    p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/txts_packer.sv
module txts_packer
    import txts_pkg::*;
#(
    parameter int CW = 4
) (
    input  cap_evt_t [NSLOT-1:0] head,
    input  logic [CW-1:0]        count,
    output logic [NSLOT-1:0]     slot_vld,
    output logic [PICK_W-1:0]    pop_n
);
    always_comb begin
        pop_n = '0;
        for (int k = 0; k < NSLOT; k++) begin
            if (k == 0) slot_vld[k] = (count != '0);
            else        slot_vld[k] = slot_vld[k-1] && (count > CW'(k))
                                      && (head[k].port == head[0].port);
            if (slot_vld[k]) pop_n = pop_n + PICK_W'(1);
        end
    end
endmodule

// File: rtl/txts_report_reg.sv
module txts_report_reg
    import txts_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  cap_evt_t [NSLOT-1:0]        head,
    input  logic [NSLOT-1:0]            slot_vld,
    output logic [PORT_W-1:0]           port_q,
    output logic [NSLOT-1:0]            vld_q,
    output logic [NSLOT-1:0][TAG_W-1:0] tag_q,
    output logic [NSLOT-1:0][RPT_W-1:0] ts_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            vld_q  <= '0;
            tag_q  <= '0;
            ts_q   <= '0;
        end else begin
            port_q <= slot_vld[0] ? head[0].port : '0;
            vld_q  <= slot_vld;
            for (int k = 0; k < NSLOT; k++) begin
                tag_q[k] <= slot_vld[k] ? head[k].tag : '0;
                ts_q[k]  <= slot_vld[k] ? head[k].ts  : '0;
            end
        end
    end

    // R3: slots fill from slot 0 with no gaps
    p_fill_low_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q == 3'b000 || vld_q == 3'b001 || vld_q == 3'b011 || vld_q == 3'b111);
    // R8: an idle cycle shows port zero and a quiet slot 0
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q == '0 |-> port_q == '0 && tag_q[0] == '0 && ts_q[0] == '0);
endmodule

// File: rtl/txts_ovf_fsm.sv
module txts_ovf_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr,
    output logic flag
);
    typedef enum logic [0:0] {OVF_CLEAN, OVF_SEEN} ovf_state_t;
    ovf_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            OVF_CLEAN: if (drop) state_nx = OVF_SEEN;
            OVF_SEEN:  if (clr && !drop) state_nx = OVF_CLEAN;
            default:   state_nx = OVF_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OVF_CLEAN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            OVF_SEEN: flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end

    // R9: any drop raises the flag at the next edge
    p_drop_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> flag);
    // R10: flag is sticky without a clear
    p_ovf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
endmodule

// File: rtl/txts_report_agg.sv
module txts_report_agg
    import txts_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LANES  = 3,
    parameter int TIME_W = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          cap_valid,
    input  logic [LANES*PORT_W-1:0]   cap_port,
    input  logic [LANES*TAG_W-1:0]    cap_tag,
    input  logic [LANES*TIME_W-1:0]   cap_time,
    input  logic                      ovf_clr,
    output logic [PORT_W-1:0]         rpt_port,
    output logic [NSLOT-1:0]          rpt_valid,
    output logic [TAG_W-1:0]          rpt_tag_0,
    output logic [TAG_W-1:0]          rpt_tag_1,
    output logic [TAG_W-1:0]          rpt_tag_2,
    output logic [RPT_W-1:0]          rpt_ts_0,
    output logic [RPT_W-1:0]          rpt_ts_1,
    output logic [RPT_W-1:0]          rpt_ts_2,
    output logic                      ovf_flag
);
    localparam int CW = $clog2(DEPTH + 1);

    cap_evt_t [LANES-1:0]        in_evt;
    cap_evt_t [NSLOT-1:0]        head;
    logic [CW-1:0]               count;
    logic [NSLOT-1:0]            slot_vld;
    logic [PICK_W-1:0]           pop_n;
    logic                        drop;
    logic [NSLOT-1:0][TAG_W-1:0] tag_q;
    logic [NSLOT-1:0][RPT_W-1:0] ts_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign in_evt[i].port = cap_port[i*PORT_W +: PORT_W];
        assign in_evt[i].tag  = cap_tag[i*TAG_W +: TAG_W];
        assign in_evt[i].ts   = cap_time[i*TIME_W +: RPT_W];
    end

    txts_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_fifo (
        .clk(clk), .rst_n(rst_n), .in_valid(cap_valid), .in_evt(in_evt),
        .pop_n(pop_n), .head(head), .count(count), .drop(drop)
    );

    txts_packer #(.CW(CW)) u_pack (
        .head(head), .count(count), .slot_vld(slot_vld), .pop_n(pop_n)
    );

    txts_report_reg u_rpt (
        .clk(clk), .rst_n(rst_n), .head(head), .slot_vld(slot_vld),
        .port_q(rpt_port), .vld_q(rpt_valid), .tag_q(tag_q), .ts_q(ts_q)
    );

    txts_ovf_fsm u_ovf (
        .clk(clk), .rst_n(rst_n), .drop(drop), .clr(ovf_clr), .flag(ovf_flag)
    );

    assign rpt_tag_0 = tag_q[0];
    assign rpt_tag_1 = tag_q[1];
    assign rpt_tag_2 = tag_q[2];
    assign rpt_ts_0  = ts_q[0];
    assign rpt_ts_1  = ts_q[1];
    assign rpt_ts_2  = ts_q[2];
endmodule

// File: tb/txts_report_agg_tb.sv
module txts_report_agg_tb;
    localparam int TIME_W = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   cap_valid = '0;
    logic [8:0]   cap_port = '0;
    logic [23:0]  cap_tag = '0;
    logic [143:0] cap_time = '0;
    logic         ovf_clr = 1'b0;
    logic [2:0]   rpt_port, rpt_valid;
    logic [7:0]   rpt_tag_0, rpt_tag_1, rpt_tag_2;
    logic [31:0]  rpt_ts_0, rpt_ts_1, rpt_ts_2;
    logic         ovf_flag;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] tag_ctr = 8'h10;
    logic [42:0] exp_q[$];

    always #10 clk = ~clk;

    txts_report_agg #(.DEPTH(8), .LANES(3), .TIME_W(TIME_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_port(cap_port),
        .cap_tag(cap_tag), .cap_time(cap_time), .ovf_clr(ovf_clr),
        .rpt_port(rpt_port), .rpt_valid(rpt_valid),
        .rpt_tag_0(rpt_tag_0), .rpt_tag_1(rpt_tag_1), .rpt_tag_2(rpt_tag_2),
        .rpt_ts_0(rpt_ts_0), .rpt_ts_1(rpt_ts_1), .rpt_ts_2(rpt_ts_2),
        .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle of lanes at a negedge; keep[] marks the lanes the
    // requirements say are accepted (R9). Returns at the negedge after the edge.
    task automatic push3(input logic [2:0] v, input logic [2:0] keep,
                         input logic [8:0] ports, input logic clr);
        logic [47:0] t;
        for (int i = 0; i < 3; i++) begin
            t = {tag_ctr, 8'h5A, $urandom()};
            cap_tag[i*8 +: 8]         = tag_ctr;
            cap_time[i*TIME_W +: TIME_W] = t;
            if (keep[i]) exp_q.push_back({ports[i*3 +: 3], tag_ctr, t[31:0]});
            tag_ctr = tag_ctr + 8'd1;
        end
        cap_valid = v;
        cap_port  = ports;
        ovf_clr   = clr;
        @(negedge clk);
        cap_valid = '0;
        ovf_clr   = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0]  tg [3];
            logic [31:0] ts [3];
            logic [42:0] e;
            tg = '{rpt_tag_0, rpt_tag_1, rpt_tag_2};
            ts = '{rpt_ts_0, rpt_ts_1, rpt_ts_2};
            if (!(rpt_valid inside {3'b000, 3'b001, 3'b011, 3'b111}))
                chk(1'b0, "R3 slot fill order", 64'(rpt_valid), 64'h7);
            for (int k = 0; k < 3; k++) begin
                if (rpt_valid[k]) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected report", 64'(tg[k]), 64'h0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(rpt_port == e[42:40], "R5 port", 64'(rpt_port), 64'(e[42:40]));
                        chk(tg[k] == e[39:32], "R6 tag", 64'(tg[k]), 64'(e[39:32]));
                        chk(ts[k] == e[31:0], "R7 timestamp", 64'(ts[k]), 64'(e[31:0]));
                    end
                end else begin
                    chk(tg[k] == 8'h0 && ts[k] == 32'h0, "R8 idle slot zero",
                        {24'h0, tg[k], ts[k]}, 64'h0);
                end
            end
            if (rpt_valid == 3'b000)
                chk(rpt_port == 3'd0, "R8 idle port zero", 64'(rpt_port), 64'h0);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rpt_valid == 3'b000 && rpt_port == 3'd0, "R1 reset valid/port",
            {58'h0, rpt_valid, rpt_port}, 64'h0);
        chk(rpt_tag_0 == 0 && rpt_ts_2 == 0 && ovf_flag == 1'b0, "R1 reset data/flag",
            {23'h0, ovf_flag, rpt_tag_0, rpt_ts_2}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rpt_valid == 3'b000, "R1 after release", 64'(rpt_valid), 64'h0);

        // R2 latency, single event on lane 0, port 2
        push3(3'b001, 3'b001, 9'b000_000_010, 1'b0);
        chk(rpt_valid == 3'b000, "R2 not before N+1", 64'(rpt_valid), 64'h0);
        @(negedge clk);
        chk(rpt_valid == 3'b001, "R2 visible after N+1", 64'(rpt_valid), 64'h1);
        @(negedge clk);

        // R4 full batch of three for port 5
        push3(3'b111, 3'b111, 9'b101_101_101, 1'b0);
        @(negedge clk);
        chk(rpt_valid == 3'b111, "R4 three slots", 64'(rpt_valid), 64'h7);
        chk(rpt_port == 3'd5, "R4 batch port", 64'(rpt_port), 64'h5);
        @(negedge clk);

        // R5 port split: lanes 1,1,4
        push3(3'b111, 3'b111, 9'b100_001_001, 1'b0);
        @(negedge clk);
        chk(rpt_valid == 3'b011 && rpt_port == 3'd1, "R5 first run",
            {58'h0, rpt_valid, rpt_port}, {58'h0, 3'b011, 3'd1});
        @(negedge clk);
        chk(rpt_valid == 3'b001 && rpt_port == 3'd4, "R5 second run",
            {58'h0, rpt_valid, rpt_port}, {58'h0, 3'b001, 3'd4});
        @(negedge clk);

        // R9/R10 overflow with alternating ports 1,2,1 (occupancy 3,5,7)
        push3(3'b111, 3'b111, 9'b001_010_001, 1'b0);
        push3(3'b111, 3'b111, 9'b001_010_001, 1'b0);
        push3(3'b111, 3'b111, 9'b001_010_001, 1'b0);
        chk(ovf_flag == 1'b0, "R9 no drop yet", 64'(ovf_flag), 64'h0);
        push3(3'b111, 3'b001, 9'b001_010_001, 1'b0); // free 1
        chk(ovf_flag == 1'b1, "R9 drop raises flag", 64'(ovf_flag), 64'h1);
        push3(3'b111, 3'b011, 9'b001_010_001, 1'b1); // free 2, clear with drop
        chk(ovf_flag == 1'b1, "R10 drop beats clear", 64'(ovf_flag), 64'h1);
        @(negedge clk);
        chk(ovf_flag == 1'b1, "R10 sticky", 64'(ovf_flag), 64'h1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R10 cleared", 64'(ovf_flag), 64'h0);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all delivered after overflow", 64'(exp_q.size()), 64'h0);

        // R3 stream: same port inside a cycle, varying masks
        for (int c = 0; c < 60; c++) begin
            logic [2:0] m, p;
            m = 3'($urandom());
            p = 3'($urandom());
            push3(m, m, {p, p, p}, 1'b0);
        end
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R3 stream fully delivered", 64'(exp_q.size()), 64'h0);
        chk(ovf_flag == 1'b0, "R9 no spurious drop", 64'(ovf_flag), 64'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule